// File: doc/BRIEF.md
# Nibble-Oriented Decimal Microcontroller Core

This block is a compact processor core for decimal arithmetic microcode. Program storage and data storage are separate, each with its own address space and port. Instructions are always 12 bits wide. The data space is addressed per 4-bit digit, and each location holds one BCD digit. Multi-digit mantissas are processed one digit at a time. An add-with-carry is followed by a decimal-adjust step, and the carry flag links each digit to the next.

The core holds two digit registers. A is the accumulator and B is the second operand. It also holds a carry flag C, a zero flag Z, an 8-bit program counter and one return-address register. The sequencer is a three-state machine:

- PRIME: the state held during reset. Its one transition leads to EXEC on the first clock after reset is released.
- EXEC: runs one instruction per clock. On a halt instruction it takes the transition to HALT. Otherwise it stays in EXEC.
- HALT: absorbing. Only reset leaves it.

Program memory is read synchronously: the core drives the next fetch address, and the word arrives one clock later. Data memory reads are combinational from `dmem_addr`. Data memory writes happen on the clock edge.

Top module: `nib_bcd_core`

## Requirements
- R1: While reset is low, `pmem_addr`=0, `dmem_we`=0 and `halted`=0. Reset clears the program counter, A, B, C, Z and the return register. The instruction at address 0 executes in the first clock after reset is released.
- R2: In EXEC, each clock executes one instruction. For any instruction that is not a jump, call, return or halt, `pmem_addr` shows the program counter plus 1, wrapping modulo 256.
- R3: The opcode is `insn[11:8]`:
  - 0 = ALU op using B as operand.
  - 1 = ALU op using the immediate `insn[3:0]` as operand.
  - 2 = load A from data address `insn[7:0]`.
  - 3 = load B from data address `insn[7:0]`.
  - 4 = store A to data address `insn[7:0]`.
  - 5 = jump; 6 = jump if C; 7 = jump if not C; 8 = jump if Z; 9 = jump if not Z. The target is `insn[7:0]`.
  - 10 = call `insn[7:0]`; 11 = return; 12 = halt.
  - Opcodes 13 to 15 are no-ops. They change no register and do not write.
- R4: The ALU function is `insn[7:4]`; b below is the operand selected by the opcode. Functions 0 to 3 compute A+b, A+b+C, A−b and A−b−C. Functions 11 and 12 compute A+1 and A−1. Each of these writes the low 4 bits to A. C becomes the carry out, or the borrow for subtraction.
- R5: Function 4 (decimal adjust after add) applies when C=1 or A>9. It then adds 6 to A modulo 16 and sets C=1. Function 5 (decimal adjust after subtract) applies under the same condition. It then subtracts 6 from A modulo 16 and sets C=1. When the condition does not hold, A and C are unchanged.
- R6: The bitwise functions clear C: 6 is AND, 7 is OR, 8 is XOR. Function 9 shifts A left by one bit and C takes the old bit 3. Function 10 shifts A right by one bit and C takes the old bit 0. Function 13 copies b into A and leaves C unchanged. Functions 14 and 15 change neither A nor the flags.
- R7: Every ALU function 0 to 13 sets Z when its 4-bit result is zero. Loads, stores, jumps, call, return and the no-op opcodes leave C and Z unchanged.
- R8: A load reads `dmem_rdata` at `dmem_addr`=`insn[7:0]` in the same clock. A store drives `dmem_we`=1, `dmem_addr`=`insn[7:0]` and `dmem_wdata`=A. `dmem_we` is 0 in every other clock.
- R9: The unconditional jump always goes to its target. The carry jumps (6 and 7) go to their target only when the flag condition holds, and otherwise fall through to the program counter plus 1. In both cases `pmem_addr` shows the chosen address.
- R10: A call saves the program counter plus 1 in the return register and goes to its target. A return goes to the saved address.
- R11: After a halt instruction executes, `halted` is 1 from the next clock until reset. During that time `pmem_addr` stays at the halt address and `dmem_we` stays 0.
- R12: A program built from digit-wise add-with-carry and decimal-adjust steps stores the correct BCD sum digits of two 8-digit numbers, plus the final carry digit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pmem_addr | output | 8 | Address of the next instruction fetch |
| pmem_rdata | input | 12 | Instruction word, registered by program memory |
| dmem_addr | output | 8 | Data digit address (`insn[7:0]`) |
| dmem_rdata | input | 4 | Digit read combinationally at `dmem_addr` |
| dmem_we | output | 1 | Write strobe for a store |
| dmem_wdata | output | 4 | Digit to write (accumulator) |
| halted | output | 1 | Core is in the HALT state |

## Verification
A wrong program counter, a wrong return register or a wrong flag shows up on `pmem_addr` in the same clock as the jump, call or return that depends on it. A wrong accumulator shows up on `dmem_wdata` at the next store. Every test program stores after each operation and branches on the flags right after, so any error in internal state reaches the ports within two or three clocks. A cycle-level behavioural model in the bench predicts fetch address, write strobe, write address and write data on every clock. The bench also checks the stored sum digits against integer arithmetic.

// File: rtl/nbc_pkg.sv
package nbc_pkg;

    localparam int INSN_W  = 12;
    localparam int OPC_W   = 4;
    localparam int DIG_W   = 4;
    localparam int FIELD_W = INSN_W - OPC_W;
    localparam int PADDR_W = FIELD_W;
    localparam int DADDR_W = FIELD_W;

    typedef enum logic [OPC_W-1:0] {
        OP_ALUB = 4'd0,
        OP_ALUI = 4'd1,
        OP_LDA  = 4'd2,
        OP_LDB  = 4'd3,
        OP_STA  = 4'd4,
        OP_JMP  = 4'd5,
        OP_JC   = 4'd6,
        OP_JNC  = 4'd7,
        OP_JZ   = 4'd8,
        OP_JNZ  = 4'd9,
        OP_CALL = 4'd10,
        OP_RET  = 4'd11,
        OP_HALT = 4'd12,
        OP_R13  = 4'd13,
        OP_R14  = 4'd14,
        OP_R15  = 4'd15
    } opc_e;

    typedef enum logic [3:0] {
        F_ADD  = 4'd0,
        F_ADC  = 4'd1,
        F_SUB  = 4'd2,
        F_SBC  = 4'd3,
        F_DAA  = 4'd4,
        F_DAS  = 4'd5,
        F_AND  = 4'd6,
        F_OR   = 4'd7,
        F_XOR  = 4'd8,
        F_SHL  = 4'd9,
        F_SHR  = 4'd10,
        F_INC  = 4'd11,
        F_DEC  = 4'd12,
        F_MOV  = 4'd13,
        F_NP14 = 4'd14,
        F_NP15 = 4'd15
    } func_e;

    typedef enum logic [2:0] {
        BR_NONE,
        BR_ALWAYS,
        BR_C,
        BR_NC,
        BR_Z,
        BR_NZ,
        BR_CALL,
        BR_RET
    } br_e;

    typedef enum logic [1:0] {
        ST_PRIME,
        ST_EXEC,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic               alu_en;
        logic               use_imm;
        func_e              func;
        logic [DIG_W-1:0]   imm;
        logic               ld_a;
        logic               ld_b;
        logic               st_a;
        br_e                br;
        logic               halt;
        logic [FIELD_W-1:0] field;
    } ctl_t;

endpackage

// File: rtl/nbc_decode.sv
module nbc_decode
    import nbc_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output ctl_t              ctl
);

    always_comb begin
        ctl         = '0;
        ctl.field   = insn[FIELD_W-1:0];
        ctl.imm     = insn[DIG_W-1:0];
        ctl.func    = func_e'(insn[FIELD_W-1:FIELD_W-4]);
        ctl.br      = BR_NONE;
        unique case (opc_e'(insn[INSN_W-1:FIELD_W]))
            OP_ALUB: ctl.alu_en = 1'b1;
            OP_ALUI: begin
                ctl.alu_en  = 1'b1;
                ctl.use_imm = 1'b1;
            end
            OP_LDA:  ctl.ld_a = 1'b1;
            OP_LDB:  ctl.ld_b = 1'b1;
            OP_STA:  ctl.st_a = 1'b1;
            OP_JMP:  ctl.br   = BR_ALWAYS;
            OP_JC:   ctl.br   = BR_C;
            OP_JNC:  ctl.br   = BR_NC;
            OP_JZ:   ctl.br   = BR_Z;
            OP_JNZ:  ctl.br   = BR_NZ;
            OP_CALL: ctl.br   = BR_CALL;
            OP_RET:  ctl.br   = BR_RET;
            OP_HALT: ctl.halt = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/nbc_alu.sv
module nbc_alu
    import nbc_pkg::*;
(
    input  func_e            func,
    input  logic [DIG_W-1:0] a,
    input  logic [DIG_W-1:0] b,
    input  logic             cin,
    output logic [DIG_W-1:0] res,
    output logic             cout,
    output logic             active
);

    localparam logic [DIG_W-1:0] DEC_MAX = DIG_W'(9);
    localparam logic [DIG_W-1:0] DEC_FIX = DIG_W'(6);

    logic [DIG_W:0] s;
    logic           adj;

    assign adj = cin || (a > DEC_MAX);

    always_comb begin
        res    = a;
        cout   = cin;
        active = 1'b1;
        s      = '0;
        unique case (func)
            F_ADD: begin
                s = {1'b0, a} + {1'b0, b};
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_ADC: begin
                s = {1'b0, a} + {1'b0, b} + (DIG_W+1)'(cin);
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_SUB: begin
                s = {1'b0, a} - {1'b0, b};
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_SBC: begin
                s = {1'b0, a} - {1'b0, b} - (DIG_W+1)'(cin);
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_DAA: if (adj) begin
                res = a + DEC_FIX; cout = 1'b1;
            end
            F_DAS: if (adj) begin
                res = a - DEC_FIX; cout = 1'b1;
            end
            F_AND: begin res = a & b; cout = 1'b0; end
            F_OR:  begin res = a | b; cout = 1'b0; end
            F_XOR: begin res = a ^ b; cout = 1'b0; end
            F_SHL: begin res = {a[DIG_W-2:0], 1'b0}; cout = a[DIG_W-1]; end
            F_SHR: begin res = {1'b0, a[DIG_W-1:1]}; cout = a[0]; end
            F_INC: begin
                s = {1'b0, a} + (DIG_W+1)'(1);
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_DEC: begin
                s = {1'b0, a} - (DIG_W+1)'(1);
                res = s[DIG_W-1:0]; cout = s[DIG_W];
            end
            F_MOV: res = b;
            default: active = 1'b0;
        endcase
    end

    always_comb begin
        if (func == F_INC)
            assert_inc_wrap_R4: assert (cout == (a == '1));
        if (func == F_DEC)
            assert_dec_borrow_R4: assert (cout == (a == '0));
        if (func == F_DAA && !cin && a <= DEC_MAX)
            assert_daa_keep_R5: assert (res == a && !cout);
        if (func == F_AND || func == F_OR || func == F_XOR)
            assert_logic_clear_R6: assert (!cout);
    end

endmodule

// File: rtl/nbc_seq.sv
module nbc_seq
    import nbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               halt_req,
    input  br_e                br,
    input  logic [PADDR_W-1:0] target,
    input  logic               c_flag,
    input  logic               z_flag,
    output logic [PADDR_W-1:0] pmem_addr,
    output logic               exec,
    output logic               halted
);

    state_e             state_q, state_n;
    logic [PADDR_W-1:0] pc_q, pc_n, ret_q, ret_n, pc_inc;

    assign pc_inc = pc_q + PADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            pc_q    <= '0;
            ret_q   <= '0;
        end else begin
            state_q <= state_n;
            pc_q    <= pc_n;
            ret_q   <= ret_n;
        end
    end

    always_comb begin
        state_n = state_q;
        pc_n    = pc_q;
        ret_n   = ret_q;
        unique case (state_q)
            ST_PRIME: state_n = ST_EXEC;
            ST_EXEC: begin
                pc_n = pc_inc;
                if (halt_req) begin
                    state_n = ST_HALT;
                    pc_n    = pc_q;
                end else begin
                    unique case (br)
                        BR_ALWAYS: pc_n = target;
                        BR_C:      if (c_flag)  pc_n = target;
                        BR_NC:     if (!c_flag) pc_n = target;
                        BR_Z:      if (z_flag)  pc_n = target;
                        BR_NZ:     if (!z_flag) pc_n = target;
                        BR_CALL: begin
                            pc_n  = target;
                            ret_n = pc_inc;
                        end
                        BR_RET:    pc_n = ret_q;
                        default: ;
                    endcase
                end
            end
            ST_HALT: ;
            default: state_n = ST_PRIME;
        endcase
    end

    always_comb begin
        pmem_addr = pc_n;
        exec      = (state_q == ST_EXEC);
        halted    = (state_q == ST_HALT);
    end

    assert_seq_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halt_req && br == BR_NONE) |=> (pc_q == $past(pc_q) + PADDR_W'(1)));

    assert_call_link_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halt_req && br == BR_CALL) |=> (ret_q == $past(pc_q) + PADDR_W'(1)));

    assert_ret_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !halt_req && br == BR_RET) |=> (pc_q == $past(ret_q)));

    assert_halt_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pmem_addr)));

endmodule

// File: rtl/nib_bcd_core.sv
module nib_bcd_core
    import nbc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [PADDR_W-1:0] pmem_addr,
    input  logic [INSN_W-1:0]  pmem_rdata,
    output logic [DADDR_W-1:0] dmem_addr,
    input  logic [DIG_W-1:0]   dmem_rdata,
    output logic               dmem_we,
    output logic [DIG_W-1:0]   dmem_wdata,
    output logic               halted
);

    ctl_t             ctl;
    logic             exec;
    logic [DIG_W-1:0] a_q, b_q, alu_b, alu_res;
    logic             c_q, z_q, alu_c, alu_act;

    nbc_decode u_dec (
        .insn (pmem_rdata),
        .ctl  (ctl)
    );

    assign alu_b = ctl.use_imm ? ctl.imm : b_q;

    nbc_alu u_alu (
        .func   (ctl.func),
        .a      (a_q),
        .b      (alu_b),
        .cin    (c_q),
        .res    (alu_res),
        .cout   (alu_c),
        .active (alu_act)
    );

    nbc_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_req  (ctl.halt),
        .br        (ctl.br),
        .target    (ctl.field),
        .c_flag    (c_q),
        .z_flag    (z_q),
        .pmem_addr (pmem_addr),
        .exec      (exec),
        .halted    (halted)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
            c_q <= 1'b0;
            z_q <= 1'b0;
        end else if (exec) begin
            if (ctl.ld_a) a_q <= dmem_rdata;
            if (ctl.ld_b) b_q <= dmem_rdata;
            if (ctl.alu_en && alu_act) begin
                a_q <= alu_res;
                c_q <= alu_c;
                z_q <= (alu_res == '0);
            end
        end
    end

    assign dmem_addr  = ctl.field;
    assign dmem_we    = exec && ctl.st_a;
    assign dmem_wdata = a_q;

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ctl.alu_en && alu_act) |=> (z_q == (a_q == '0)));

    assert_flags_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && !ctl.alu_en) |=> ($stable(c_q) && $stable(z_q)));

    assert_load_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && ctl.ld_a) |=> (a_q == $past(dmem_rdata)));

    assert_no_write_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> !halted);

endmodule

// File: tb/test_nib_bcd_core.sv
module test_nib_bcd_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pmem_addr;
    logic [11:0] pmem_rdata;
    logic [7:0]  dmem_addr;
    logic [3:0]  dmem_rdata;
    logic        dmem_we;
    logic [3:0]  dmem_wdata;
    logic        halted;

    logic [11:0] rom  [256];
    logic [3:0]  dram [256];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_state;   // 1 = executing, 2 = halted
    int m_pc, m_a, m_b, m_c, m_z, m_ret;
    int mmem [256];
    string m_req = "R6";

    always #2 clk = ~clk;

    always @(posedge clk) begin
        pmem_rdata <= rom[pmem_addr];
        if (dmem_we) dram[dmem_addr] <= dmem_wdata;
    end
    assign dmem_rdata = dram[dmem_addr];

    nib_bcd_core i_nib_bcd_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .pmem_addr  (pmem_addr),
        .pmem_rdata (pmem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_we    (dmem_we),
        .dmem_wdata (dmem_wdata),
        .halted     (halted)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_alu(int f, int b);
        int a = m_a;
        int r = m_a;
        int nc = m_c;
        bit upd = 1'b1;
        case (f)
            0:  begin r = a + b;       nc = (r > 15); end
            1:  begin r = a + b + m_c; nc = (r > 15); end
            2:  begin r = a - b;       nc = (r < 0);  end
            3:  begin r = a - b - m_c; nc = (r < 0);  end
            4:  if (m_c != 0 || a > 9) begin r = a + 6; nc = 1; end
            5:  if (m_c != 0 || a > 9) begin r = a - 6; nc = 1; end
            6:  begin r = a & b; nc = 0; end
            7:  begin r = a | b; nc = 0; end
            8:  begin r = a ^ b; nc = 0; end
            9:  begin r = a * 2; nc = (a >= 8); end
            10: begin r = a / 2; nc = a % 2; end
            11: begin r = a + 1; nc = (r > 15); end
            12: begin r = a - 1; nc = (r < 0); end
            13: r = b;
            default: upd = 1'b0;
        endcase
        if (f <= 3 || f == 11 || f == 12) m_req = "R4";
        else if (f == 4 || f == 5) m_req = "R5";
        else m_req = "R6";
        if (upd) begin
            m_a = r & 15;
            m_c = nc;
            m_z = (m_a == 0);
        end
    endtask

    task automatic model_exec();
        int ins, op, fld, npc;
        string tag;
        ins = rom[m_pc];
        op  = ins >> 8;
        fld = ins & 255;
        npc = (m_pc + 1) % 256;
        case (op)
            5:  npc = fld;
            6:  if (m_c != 0) npc = fld;
            7:  if (m_c == 0) npc = fld;
            8:  if (m_z != 0) npc = fld;
            9:  if (m_z == 0) npc = fld;
            10: begin m_ret = (m_pc + 1) % 256; npc = fld; end
            11: npc = m_ret;
            12: npc = m_pc;
            default: ;
        endcase
        if (op <= 4) tag = "R2";
        else if (op <= 7) tag = "R9";
        else if (op <= 9) tag = "R7";
        else if (op <= 11) tag = "R10";
        else if (op == 12) tag = "R11";
        else tag = "R3";
        chk(tag, "pmem_addr", pmem_addr, npc);
        chk("R11", "halted", halted, 0);
        chk("R8", "dmem_we", dmem_we, (op == 4));
        if (op >= 2 && op <= 4) chk("R8", "dmem_addr", dmem_addr, fld);
        if (op == 4) begin
            chk(m_req, "dmem_wdata", dmem_wdata, m_a);
            mmem[fld] = m_a;
        end
        if (op == 2) begin m_a = mmem[fld]; m_req = "R8"; end
        if (op == 3) m_b = mmem[fld];
        if (op <= 1) model_alu((ins >> 4) & 15, (op == 1) ? (ins & 15) : m_b);
        m_pc = npc;
        if (op == 12) m_state = 2;
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                chk("R1", "reset pmem_addr", pmem_addr, 0);
                chk("R1", "reset dmem_we", dmem_we, 0);
                chk("R1", "reset halted", halted, 0);
                m_state = 1; m_pc = 0; m_a = 0; m_b = 0;
                m_c = 0; m_z = 0; m_ret = 0;
            end else if (m_state == 1) begin
                model_exec();
            end else begin
                chk("R11", "halted", halted, 1);
                chk("R11", "dmem_we in halt", dmem_we, 0);
                chk("R11", "pmem_addr in halt", pmem_addr, m_pc);
            end
        end
    end

    task automatic enter_reset();
        @(negedge clk);
        #1 rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            rom[i]  = 12'hC00;
            dram[i] = 4'd0;
            mmem[i] = 0;
        end
    endtask

    task automatic run_to_halt();
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 2000 && !halted; i++) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R11", "halt reached", halted, 1);
    endtask

    task automatic emit(inout int pc, input int w);
        rom[pc] = w[11:0];
        pc++;
    endtask

    task automatic run_add(longint x, longint y);
        int pc = 0;
        longint p = 1;
        longint s = x + y;
        enter_reset();
        for (int i = 0; i < 8; i++) begin
            dram[16 + i] = 4'((x / p) % 10);
            dram[32 + i] = 4'((y / p) % 10);
            mmem[16 + i] = int'((x / p) % 10);
            mmem[32 + i] = int'((y / p) % 10);
            p = p * 10;
        end
        emit(pc, 'h160);
        for (int i = 0; i < 8; i++) begin
            emit(pc, 'h210 + i);
            emit(pc, 'h320 + i);
            emit(pc, 'h010);
            emit(pc, 'h140);
            emit(pc, 'h430 + i);
        end
        emit(pc, 'hA00 | (pc + 2));
        emit(pc, 'hC00);
        emit(pc, 'h1D0);
        emit(pc, 'h110);
        emit(pc, 'h438);
        emit(pc, 'hB00);
        run_to_halt();
        p = 1;
        for (int i = 0; i < 8; i++) begin
            chk("R12", "sum digit", int'(dram[48 + i]), int'((s / p) % 10));
            p = p * 10;
        end
        chk("R12", "carry digit", int'(dram[56]), int'(s / p));
    endtask

    task automatic run_ops(int sd);
        int pc = 0;
        int k = 0;
        enter_reset();
        for (int i = 0; i < 16; i++) begin
            dram[64 + i] = 4'(i);
            mmem[64 + i] = i;
        end
        while (pc < 246) begin
            int f = (k + sd) % 16;
            int a = (k * 7 + 3 + sd) % 16;
            int b = (k * 5 + 1 + sd * 3) % 16;
            int cin = ((k + sd) / 3) % 2;
            int jops [5] = '{6, 7, 8, 9, 5};
            if (cin != 0) begin
                emit(pc, 'h1DF);
                emit(pc, 'h1B0);
            end else begin
                emit(pc, 'h160);
                emit(pc, 'hD00 | k);
            end
            emit(pc, 'h1D0 | a);
            if (k % 2 != 0) begin
                emit(pc, 'h340 | b);
                emit(pc, f << 4);
            end else begin
                emit(pc, 'h100 | (f << 4) | b);
            end
            emit(pc, 'h480 | (k % 64));
            emit(pc, (jops[k % 5] << 8) | (pc + 2));
            emit(pc, (k % 2 != 0) ? ('hF00 | k) : 'hE55);
            k++;
        end
        emit(pc, 'hC00);
        run_to_halt();
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            rom[i]  = 12'hC00;
            dram[i] = 4'd0;
        end
        run_add(64'd12345678, 64'd87654321);
        run_add(64'd99999999, 64'd1);
        run_add(64'd0, 64'd0);
        run_add(64'd50505050, 64'd49494950);
        run_add(64'd99999999, 64'd99999999);
        run_add(64'd31415926, 64'd27182818);
        run_ops(0);
        run_ops(5);
        run_ops(11);
        run_ops(2);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule